// File: doc/BRIEF.md
# ADC Register Front End with Power Sequencing

This block is the digital control front end of a successive-approximation converter. Software reaches it through a simple memory-mapped register bus. Writes take effect on the clock edge. Reads are combinational from the address. The block keeps control, status, configuration, channel preselect, sampling-time, differential-select, first-sequence-entry and result registers.

Before any conversion can run, the block enforces a strict power-up order. First the converter leaves deep power-down and the regulator is switched on. A regulator-ready flag then appears after a settling count. Only after that can the converter be enabled, and an ADC-ready flag follows after a second count. A software start then runs one conversion on the channel named in the sequence register.

The analog core is a behavioural port pair. The block issues a one-cycle start strobe together with a channel number. The core answers with a done strobe and a result word.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset the control word (offset 0x08) reads 0x2000_0000, with only the deep power-down bit 29 set. The status word (0x00), result (0x40) and configuration (0x0C) read 0.
- R2: A control write with bit 29 set forces the regulator-enable bit 28 to 0, whatever value is written there. From the following cycle, regulator-ready (status bit 12) and ADC-ready (status bit 0) both read 0.
- R3: Once bit 29 is 0 and bit 28 is 1 after a control write, status bit 12 rises exactly REG_DLY clock edges later.
- R4: Writing 1 to control bit 0 (enable) is accepted only while status bit 12 is 1. Once enable is set, status bit 0 rises exactly RDY_DLY clock edges later.
- R5: Writing 1 to control bit 2 (start) starts one conversion. The block emits a one-cycle `conv_start` with `conv_chan` equal to bits [6 +: CH_W] of the sequence register (0x30). On `conv_done`, the result register takes `conv_result`, status bit 2 (end of conversion) sets, and control bit 2 clears.
- R6: A start is ignored unless status bit 0 is 1 and configuration bits 11:10 and 1:0 are all zero. An ignored start produces no `conv_start`, and control bit 2 stays 0.
- R7: The end-of-conversion flag clears when the result register is read, or when 1 is written to status bit 2.
- R8: Writing 1 to control bit 1 (disable) while enabled clears enable and ADC-ready once no conversion is in progress, and bit 1 then reads 0 again. A conversion already under way completes first.
- R9: Configuration (0x0C), sampling time (0x14, 0x18), channel preselect (0x1C), sequence (0x30) and differential select (0xC0) read back whatever was written to them. An unmapped offset reads 0.
- R10: A `conv_done` that arrives while no conversion is in progress changes neither the result register nor the end-of-conversion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| conv_start | output | 1 | One-cycle request to the analog core |
| conv_chan | output | CH_W | Channel to convert |
| conv_done | input | 1 | Conversion finished strobe |
| conv_result | input | RES_W | Conversion result |

## Verification
Assertions check on every cycle the invariants of the power order: regulator enable is never set while in deep power-down, regulator-ready implies the regulator is on, and ADC-ready implies both enable and regulator-ready. They also check that each rising busy comes from a ready state with a start strobe, that a finished conversion sets the flag, that a pending disable is released, and that a stray done leaves the result untouched. The exact settling counts, the channel-to-result path across all channels, the two ways of clearing the flag, the start gating by configuration, and the ordering of a disable behind a running conversion can only be shown by the bench's scenarios.

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
  parameter int RES_W   = 16,
  parameter int CH_W    = 5,
  parameter int REG_DLY = 200,
  parameter int RDY_DLY = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);
  localparam int MAXD  = (REG_DLY > RDY_DLY) ? REG_DLY : RDY_DLY;
  localparam int CNT_W = $clog2(MAXD + 1);

  logic pwd_q, vreg_q, boost_q, en_q, dis_q, busy_q;
  logic vrdy_q, rdy_q, eoc_q, start_q;
  logic [CNT_W-1:0] vcnt_q, rcnt_q;
  logic [31:0] cfg_q, smp1_q, smp2_q, pcsel_q, sq1_q, dif_q;
  logic [RES_W-1:0] dr_q;

  wire wr_ctrl  = bus_wr && bus_addr == 8'h08;
  wire wr_isr   = bus_wr && bus_addr == 8'h00;
  wire rd_dr    = bus_rd && bus_addr == 8'h40;
  wire sw_mode  = cfg_q[11:10] == 2'b00 && cfg_q[1:0] == 2'b00;
  wire pwd_set  = wr_ctrl && bus_wdata[29];
  wire vreg_off = wr_ctrl && (bus_wdata[29] || !bus_wdata[28]);
  wire vreg_on  = vreg_q && !pwd_q;
  wire release_dis = dis_q && !busy_q;
  wire go       = wr_ctrl && bus_wdata[2] && rdy_q && !busy_q && !dis_q && sw_mode;
  wire finish   = busy_q && conv_done;

  assign conv_start = start_q;
  assign conv_chan  = sq1_q[6 +: CH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwd_q <= 1'b1; vreg_q <= 1'b0; boost_q <= 1'b0;
      en_q <= 1'b0; dis_q <= 1'b0; busy_q <= 1'b0; start_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        pwd_q   <= bus_wdata[29];
        vreg_q  <= bus_wdata[28] && !bus_wdata[29];
        boost_q <= bus_wdata[8];
      end
      if (pwd_set || release_dis) en_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[0] && vrdy_q) en_q <= 1'b1;
      if (pwd_set || release_dis) dis_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[1] && en_q) dis_q <= 1'b1;
      if (pwd_set) busy_q <= 1'b0;
      else if (go) busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      start_q <= go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0; vrdy_q <= 1'b0;
    end else if (!vreg_on || vreg_off) begin
      vcnt_q <= '0; vrdy_q <= 1'b0;
    end else if (!vrdy_q) begin
      if (vcnt_q == CNT_W'(REG_DLY - 1)) vrdy_q <= 1'b1;
      else vcnt_q <= vcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0; rdy_q <= 1'b0;
    end else if (!vreg_on || vreg_off || !vrdy_q || !en_q || pwd_set || release_dis) begin
      rcnt_q <= '0; rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (rcnt_q == CNT_W'(RDY_DLY - 1)) rdy_q <= 1'b1;
      else rcnt_q <= rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q <= 1'b0; dr_q <= '0;
    end else begin
      if (finish) begin
        eoc_q <= 1'b1;
        dr_q  <= conv_result;
      end else if (rd_dr || (wr_isr && bus_wdata[2])) begin
        eoc_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; smp1_q <= '0; smp2_q <= '0; pcsel_q <= '0; sq1_q <= '0; dif_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        8'h0C: cfg_q   <= bus_wdata;
        8'h14: smp1_q  <= bus_wdata;
        8'h18: smp2_q  <= bus_wdata;
        8'h1C: pcsel_q <= bus_wdata;
        8'h30: sq1_q   <= bus_wdata;
        8'hC0: dif_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      8'h00: bus_rdata = {19'b0, vrdy_q, 9'b0, eoc_q, 1'b0, rdy_q};
      8'h08: bus_rdata = {2'b0, pwd_q, vreg_q, 19'b0, boost_q, 5'b0, busy_q, dis_q, en_q};
      8'h0C: bus_rdata = cfg_q;
      8'h14: bus_rdata = smp1_q;
      8'h18: bus_rdata = smp2_q;
      8'h1C: bus_rdata = pcsel_q;
      8'h30: bus_rdata = sq1_q;
      8'h40: bus_rdata = 32'(dr_q);
      8'hC0: bus_rdata = dif_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_PWD_KILLS_VREG: assert property (@(posedge clk) disable iff (!rst_n)
    pwd_q |-> !vreg_q); // R2
  AST_VRDY_NEEDS_VREG: assert property (@(posedge clk) disable iff (!rst_n)
    vrdy_q |-> (vreg_q && !pwd_q)); // R3
  AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> (en_q && vrdy_q)); // R4
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(rdy_q) && conv_start)); // R6
  AST_DONE_SETS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && conv_done) |=> (eoc_q && !busy_q)); // R5
  AST_DIS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !busy_q) |=> (!en_q && !dis_q && !rdy_q)); // R8
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && conv_done) |=> $stable(dr_q)); // R10
endmodule

// File: tb/adc_ctrl_regs_test.sv
module adc_ctrl_regs_test;
  localparam int CLK_NS = 10;
  localparam int RES_W = 16, CH_W = 5, REG_DLY = 4, RDY_DLY = 3, LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic conv_start;
  logic [CH_W-1:0] conv_chan;
  logic m_done = 1'b0, s_done = 1'b0;
  logic [RES_W-1:0] m_res = '0, s_res = '0;
  wire conv_done = m_done | s_done;
  wire [RES_W-1:0] conv_result = s_done ? s_res : m_res;
  int checks = 0, errors = 0, nstarts = 0, mcnt = 0;
  logic [CH_W-1:0] seen_ch = '0;

  always #(CLK_NS/2) clk = ~clk;

  adc_ctrl_regs #(.RES_W(RES_W), .CH_W(CH_W), .REG_DLY(REG_DLY), .RDY_DLY(RDY_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result));

  function automatic logic [RES_W-1:0] expect_res(int ch);
    return RES_W'((ch * 2749 + 4660) ^ (ch << 11));
  endfunction

  always @(negedge clk) begin
    m_done <= 1'b0;
    if (conv_start) begin
      nstarts <= nstarts + 1;
      seen_ch <= conv_chan;
      mcnt <= LAT;
    end else if (mcnt > 0) begin
      mcnt <= mcnt - 1;
      if (mcnt == 1) begin
        m_done <= 1'b1;
        m_res <= expect_res(int'(seen_ch));
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic count_until(int bitpos, output int n);
    logic [31:0] v;
    n = 0;
    peek(8'h00, v);
    while (!v[bitpos] && n < 100) begin
      @(negedge clk);
      n++;
      peek(8'h00, v);
    end
  endtask

  task automatic wait_eoc();
    logic [31:0] v;
    int n = 0;
    peek(8'h00, v);
    while (!v[2] && n < 40) begin
      @(negedge clk);
      n++;
      peek(8'h00, v);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n, s0;
    logic [7:0] regs [6];
    logic [31:0] pats [4];
    regs = '{8'h0C, 8'h14, 8'h18, 8'h1C, 8'h30, 8'hC0};
    pats = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_0001, 32'h0000_0000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h08, v); check("R1 ctrl reset", v, 32'h2000_0000);
    rd(8'h00, v); check("R1 status reset", v, 0);
    rd(8'h40, v); check("R1 data reset", v, 0);
    rd(8'h0C, v); check("R1 cfg reset", v, 0);

    s0 = nstarts;
    wr(8'h08, 32'h0000_0004);
    repeat (10) @(negedge clk);
    rd(8'h08, v); check("R6 start while powered down", v[2], 0);
    check("R6 no strobe while not ready", nstarts, s0);
    wr(8'h08, 32'h0000_0001);
    rd(8'h08, v); check("R4 enable refused without regulator", v[0], 0);

    wr(8'h08, 32'h1000_0000);
    count_until(12, n); check("R3 regulator settle count", n, REG_DLY);
    rd(8'h08, v); check("R3 ctrl after regulator on", v, 32'h1000_0000);
    wr(8'h08, 32'h1000_0001);
    count_until(0, n); check("R4 ready settle count", n, RDY_DLY);

    foreach (regs[i]) foreach (pats[j]) begin
      wr(regs[i], pats[j] ^ {24'h0, regs[i]});
      rd(regs[i], v); check("R9 readback", v, pats[j] ^ {24'h0, regs[i]});
    end
    rd(8'h04, v); check("R9 unmapped", v, 0);
    rd(8'h44, v); check("R9 unmapped high", v, 0);
    wr(8'h0C, 32'h0);

    s0 = nstarts;
    wr(8'h0C, 32'h0000_0400);
    wr(8'h08, 32'h1000_0004);
    repeat (10) @(negedge clk);
    rd(8'h08, v); check("R6 start with trigger field", v[2], 0);
    wr(8'h0C, 32'h0000_0001);
    wr(8'h08, 32'h1000_0004);
    repeat (10) @(negedge clk);
    rd(8'h08, v); check("R6 start with data mgmt field", v[2], 0);
    check("R6 no strobe while blocked", nstarts, s0);
    wr(8'h0C, 32'h0);

    for (int ch = 0; ch < 20; ch++) begin
      s0 = nstarts;
      wr(8'h30, 32'(ch) << 6 | 32'h3F);
      wr(8'h08, 32'h1000_0004);
      wait_eoc();
      check("R5 one strobe", nstarts, s0 + 1);
      check("R5 channel", 32'(seen_ch), 32'(ch));
      rd(8'h08, v); check("R5 start self-clears", v[2], 0);
      if (ch % 2 == 1) begin
        wr(8'h00, 32'h0000_0004);
        rd(8'h00, v); check("R7 flag cleared by write-one", v[2], 0);
        rd(8'h40, v); check("R5 result", v, 32'(expect_res(ch)));
      end else begin
        rd(8'h40, v); check("R5 result", v, 32'(expect_res(ch)));
        rd(8'h00, v); check("R7 flag cleared by data read", v[2], 0);
      end
    end

    @(negedge clk);
    s_res = 16'hDEAD; s_done = 1'b1;
    @(negedge clk);
    s_done = 1'b0;
    rd(8'h40, v); check("R10 stray done keeps result", v, 32'(expect_res(19)));
    rd(8'h00, v); check("R10 stray done keeps flag clear", v[2], 0);

    wr(8'h30, 32'(7) << 6);
    wr(8'h08, 32'h1000_0004);
    wr(8'h08, 32'h1000_0002);
    rd(8'h08, v); check("R8 enable held during conversion", v[0], 1);
    wait_eoc();
    repeat (2) @(negedge clk);
    rd(8'h08, v); check("R8 enable dropped after conversion", v[1:0], 2'b00);
    rd(8'h00, v); check("R8 ready dropped", v[0], 0);
    rd(8'h40, v); check("R8 pending conversion completed", v, 32'(expect_res(7)));

    wr(8'h08, 32'h1000_0001);
    count_until(0, n); check("R4 ready again", n, RDY_DLY);
    wr(8'h08, 32'h1000_0002);
    @(negedge clk);
    rd(8'h08, v); check("R8 idle disable", v[1:0], 2'b00);

    wr(8'h08, 32'h1000_0001);
    count_until(0, n);
    wr(8'h08, 32'h3000_0001);
    rd(8'h08, v); check("R2 regulator enable forced off", v, 32'h2000_0000);
    rd(8'h00, v); check("R2 ready flags cleared", v, 0);

    finish_run();
  end
endmodule